// File: doc/BRIEF.md
# Variable Line-Size Direct-Mapped Data Cache

This block is a 16 KB direct-mapped data cache. Its storage is split into eight sub-arrays, each one 32 bytes wide. Each sub-array has a dedicated 256-bit path to a matching sub-array of the backing memory. Lookup works at a fixed 32-byte granularity. The address picks one sub-array and one set, and every 32-byte sub-line carries its own tag and valid bit. A hit therefore costs the same as in a plain direct-mapped cache.

The only thing that varies is the size of a refill. Software stores a 2-bit line-size code to a memory-mapped status register. On a load miss, the cache then fetches an aligned group of 1, 2, 4 or 8 neighbouring sub-lines of the same set, in one parallel transfer. The transfer takes the same time whatever the group size.

Stores are write-through with no allocation on a miss. Changing the line size affects only refills issued after the change.

Top module: `vls_dcache`

## Requirements
- R1: After reset the line-size code is 2'b00 (32 B), every sub-line is invalid, and `cpu_busy`, `cpu_ack`, `rf_req` and `mem_we` are low.
- R2: Address fields are: bits [4:2] word in the sub-line, bits [7:5] sub-array, bits [13:8] set, bits [31:14] tag. A load whose sub-line is valid with a matching tag is a hit. It raises `cpu_ack` with the word on `cpu_rdata` in the cycle after acceptance, and it issues no refill request.
- R3: A load miss raises `rf_req` for exactly one cycle, in the cycle after acceptance. `rf_addr` is the miss address with bits [7:0] cleared. `rf_mask` bit i selects sub-array i, and the mask covers 2^code sub-arrays (code 00=32 B, 01=64 B, 10=128 B, 11=256 B). The group is aligned to its own size and contains the missing sub-line.
- R4: A refill sets the valid bit and writes the miss tag for every sub-line selected by `rf_mask`. Sub-lines outside the mask keep their previous state.
- R5: A miss is answered with `cpu_ack` in the cycle after `rf_valid`. So, for a fixed memory latency, the miss latency is the same for every line size.
- R6: In a refill, sub-array i takes `rf_data[256*i +: 256]`, and word w of that sub-line is bits [32*w +: 32]. The data returned on a miss and on later hits is the backing-memory word at the requested address.
- R7: A store to `CFG_ADDR` (default 32'hFFFF_FFF0) loads `cpu_wdata[1:0]` into the line-size code. A load from `CFG_ADDR` returns the code zero-extended. Either access is acknowledged in the next cycle and reaches neither the memory write port nor the refill port.
- R8: Writing a new line-size code flushes nothing. Sub-lines resident before the write still hit afterwards.
- R9: Every store to any other address pulses `mem_we` with its address and data, and is acknowledged in the next cycle. A store hit also updates the cached word. A store miss issues no refill and allocates nothing.
- R10: `cpu_busy` is high from the cycle after a miss is accepted until the cycle its `cpu_ack` appears, and low otherwise. Only one refill is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, taken when `cpu_busy` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with `cpu_ack` |
| cpu_busy | output | 1 | A refill is outstanding |
| rf_req | output | 1 | One-cycle refill request |
| rf_addr | output | 32 | Set-aligned refill address |
| rf_mask | output | 8 | Sub-arrays activated for this refill |
| rf_valid | input | 1 | Refill data present |
| rf_data | input | 2048 | Parallel refill data, 256 bits per sub-array |
| mem_we | output | 1 | Write-through pulse |
| mem_addr | output | 32 | Write-through address |
| mem_wdata | output | 32 | Write-through data |

## Verification
A wrong valid bit or tag shows up at the ports on the next load to that sub-line. Either an unexpected `rf_req` appears one cycle after acceptance, or an expected one is missing. The bench tracks every sub-line, so the first such access is flagged.

A wrong group mask, or a wrong mapping from refill lanes to sub-arrays, is caught two ways. The mask is visible directly in the request cycle. A wrong data mapping returns a filler word, because the bench memory drives filler on unselected lanes, either on the miss itself or on the first later hit to a neighbouring sub-line.

A corrupted line-size code is exposed by the next read-back and by the next miss mask.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;
  localparam int NSUB      = 8;
  localparam int SUB_BYTES = 32;
  localparam int CAP_BYTES = 16384;
  localparam int WORD_BITS = 32;
  localparam int LSZ_W     = 2;
  localparam int SUB_BITS  = SUB_BYTES * 8;
  localparam int NSETS     = CAP_BYTES / (SUB_BYTES * NSUB);
  localparam int OFS_W     = $clog2(SUB_BYTES);
  localparam int SEL_W     = $clog2(NSUB);
  localparam int SET_W     = $clog2(NSETS);
  localparam int WSEL_W    = $clog2(SUB_BITS / WORD_BITS);
  localparam int WB_W      = $clog2(WORD_BITS / 8);
  localparam int FILL_W    = NSUB * SUB_BITS;

  typedef logic [LSZ_W-1:0] lsz_t;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctrl_st_t;

  // Aligned group of 2^lsz sub-arrays that contains sub-array sel
  function automatic logic [NSUB-1:0] group_mask(input logic [SEL_W-1:0] sel, input lsz_t lsz);
    logic [NSUB-1:0] m;
    int span;
    int base;
    span = 1 << lsz;
    if (span > NSUB) span = NSUB;
    base = (int'(sel) / span) * span;
    for (int i = 0; i < NSUB; i++) m[i] = (i >= base) && (i < base + span);
    return m;
  endfunction
endpackage

// File: rtl/vls_tag_store.sv
`timescale 1ns/1ps
module vls_tag_store
  import vls_pkg::*;
#(
  parameter int TAG_W = 18
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [SET_W-1:0] rd_set,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [NSUB-1:0]  wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [NSUB-1:0]  bank_v;
  logic [TAG_W-1:0] bank_tag [NSUB];

  for (genvar b = 0; b < NSUB; b++) begin : g_bank
    logic [TAG_W-1:0] tags [NSETS];
    logic [NSETS-1:0] vld;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        vld <= '0;
      else if (wr_en[b]) vld[wr_set] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_en[b]) tags[wr_set] <= wr_tag;
    end

    assign bank_v[b]   = vld[rd_set];
    assign bank_tag[b] = tags[rd_set];
  end

  assign rd_valid = bank_v[rd_sel];
  assign rd_tag   = bank_tag[rd_sel];
endmodule

// File: rtl/vls_data_store.sv
`timescale 1ns/1ps
module vls_data_store
  import vls_pkg::*;
(
  input  logic                 clk,
  input  logic [SEL_W-1:0]     rd_sel,
  input  logic [SET_W-1:0]     rd_set,
  input  logic [WSEL_W-1:0]    rd_word,
  output logic [WORD_BITS-1:0] rd_data,
  input  logic [NSUB-1:0]      fill_en,
  input  logic [SET_W-1:0]     fill_set,
  input  logic [FILL_W-1:0]    fill_data,
  input  logic                 ww_en,
  input  logic [SEL_W-1:0]     ww_sel,
  input  logic [SET_W-1:0]     ww_set,
  input  logic [WSEL_W-1:0]    ww_word,
  input  logic [WORD_BITS-1:0] ww_data
);
  logic [SUB_BITS-1:0] bank_line [NSUB];
  logic [SUB_BITS-1:0] sel_line;

  for (genvar b = 0; b < NSUB; b++) begin : g_bank
    logic [SUB_BITS-1:0] lines [NSETS];

    always_ff @(posedge clk) begin
      if (fill_en[b])
        lines[fill_set] <= fill_data[b*SUB_BITS +: SUB_BITS];
      else if (ww_en && (ww_sel == SEL_W'(b)))
        lines[ww_set][ww_word*WORD_BITS +: WORD_BITS] <= ww_data;
    end

    assign bank_line[b] = lines[rd_set];
  end

  assign sel_line = bank_line[rd_sel];
  assign rd_data  = sel_line[rd_word*WORD_BITS +: WORD_BITS];
endmodule

// File: rtl/vls_ctrl.sv
`timescale 1ns/1ps
module vls_ctrl
  import vls_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 32'hFFFF_FFF0
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [WORD_BITS-1:0] cpu_wdata,
  input  logic                 lk_hit,
  input  logic [WORD_BITS-1:0] lk_word,
  input  logic                 rf_valid,
  input  logic [FILL_W-1:0]    rf_data,
  output logic                 cpu_ack,
  output logic [WORD_BITS-1:0] cpu_rdata,
  output logic                 cpu_busy,
  output logic                 rf_req,
  output logic [ADDR_W-1:0]    rf_addr,
  output logic [NSUB-1:0]      rf_mask,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [WORD_BITS-1:0] mem_wdata,
  output logic [NSUB-1:0]      fill_en,
  output logic                 ww_en,
  output logic [ADDR_W-1:0]    miss_addr,
  output lsz_t                 lsz,
  output logic                 ev_accept,
  output logic                 ev_hit,
  output logic                 ev_miss,
  output logic                 ev_cfg
);
  localparam int LOW_W = OFS_W + SEL_W;
  localparam int OFS_BITS = $clog2(FILL_W);

  ctrl_st_t            st_q;
  lsz_t                lsz_q;
  logic                is_cfg;
  logic                ev_store;
  logic [SEL_W-1:0]    cpu_sel;
  logic [SEL_W-1:0]    m_sel;
  logic [WSEL_W-1:0]   m_word;
  logic [OFS_BITS-1:0] fw_ofs;
  logic [WORD_BITS-1:0] fill_word;

  assign is_cfg    = (cpu_addr == CFG_ADDR);
  assign cpu_sel   = cpu_addr[OFS_W +: SEL_W];
  assign ev_accept = cpu_req && (st_q == ST_IDLE);
  assign ev_cfg    = ev_accept && is_cfg;
  assign ev_store  = ev_accept && !is_cfg && cpu_we;
  assign ev_hit    = ev_accept && !is_cfg && !cpu_we && lk_hit;
  assign ev_miss   = ev_accept && !is_cfg && !cpu_we && !lk_hit;
  assign ww_en     = ev_store && lk_hit;
  assign fill_en   = (st_q == ST_WAIT && rf_valid) ? rf_mask : '0;
  assign cpu_busy  = (st_q != ST_IDLE);
  assign lsz       = lsz_q;

  // requested word inside the wide refill bus
  assign m_sel     = miss_addr[OFS_W +: SEL_W];
  assign m_word    = miss_addr[WB_W +: WSEL_W];
  assign fw_ofs    = {m_sel, m_word, {$clog2(WORD_BITS){1'b0}}};
  assign fill_word = rf_data[fw_ofs +: WORD_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      lsz_q     <= '0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
      rf_req    <= 1'b0;
      rf_addr   <= '0;
      rf_mask   <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      miss_addr <= '0;
    end else begin
      cpu_ack <= 1'b0;
      rf_req  <= 1'b0;
      mem_we  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (ev_cfg) begin
            cpu_ack <= 1'b1;
            if (cpu_we) begin
              lsz_q     <= cpu_wdata[LSZ_W-1:0];
              cpu_rdata <= '0;
            end else begin
              cpu_rdata <= {{(WORD_BITS-LSZ_W){1'b0}}, lsz_q};
            end
          end else if (ev_store) begin
            cpu_ack   <= 1'b1;
            cpu_rdata <= '0;
            mem_we    <= 1'b1;
            mem_addr  <= cpu_addr;
            mem_wdata <= cpu_wdata;
          end else if (ev_hit) begin
            cpu_ack   <= 1'b1;
            cpu_rdata <= lk_word;
          end else if (ev_miss) begin
            st_q      <= ST_WAIT;
            rf_req    <= 1'b1;
            miss_addr <= cpu_addr;
            rf_addr   <= {cpu_addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
            rf_mask   <= group_mask(cpu_sel, lsz_q);
          end
        end
        ST_WAIT: begin
          if (rf_valid) begin
            st_q      <= ST_IDLE;
            cpu_ack   <= 1'b1;
            cpu_rdata <= fill_word;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vls_dcache.sv
`timescale 1ns/1ps
module vls_dcache
  import vls_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 32'hFFFF_FFF0
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [WORD_BITS-1:0] cpu_wdata,
  output logic                 cpu_ack,
  output logic [WORD_BITS-1:0] cpu_rdata,
  output logic                 cpu_busy,
  output logic                 rf_req,
  output logic [ADDR_W-1:0]    rf_addr,
  output logic [NSUB-1:0]      rf_mask,
  input  logic                 rf_valid,
  input  logic [FILL_W-1:0]    rf_data,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [WORD_BITS-1:0] mem_wdata
);
  localparam int TAG_W = ADDR_W - OFS_W - SEL_W - SET_W;

  // lookup fields of the presented address
  logic [SEL_W-1:0]     lk_sel;
  logic [SET_W-1:0]     lk_set;
  logic [TAG_W-1:0]     lk_tag;
  logic [WSEL_W-1:0]    lk_wsel;
  logic                 rd_valid;
  logic [TAG_W-1:0]     rd_tag;
  logic                 lk_hit;
  logic [WORD_BITS-1:0] lk_word;

  // events brought out for the checker
  logic                 ev_accept;
  logic                 ev_hit;
  logic                 ev_miss;
  logic                 ev_cfg;
  lsz_t                 lsz_q;
  logic [SEL_W-1:0]     miss_sel;

  logic [NSUB-1:0]      fill_en;
  logic                 ww_en;
  logic [ADDR_W-1:0]    miss_addr;

  assign lk_sel   = cpu_addr[OFS_W +: SEL_W];
  assign lk_set   = cpu_addr[OFS_W+SEL_W +: SET_W];
  assign lk_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
  assign lk_wsel  = cpu_addr[WB_W +: WSEL_W];
  assign lk_hit   = rd_valid && (rd_tag == lk_tag);
  assign miss_sel = miss_addr[OFS_W +: SEL_W];

  vls_tag_store #(.TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel   (lk_sel),
    .rd_set   (lk_set),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .wr_en    (fill_en),
    .wr_set   (miss_addr[OFS_W+SEL_W +: SET_W]),
    .wr_tag   (miss_addr[ADDR_W-1 -: TAG_W])
  );

  vls_data_store u_data (
    .clk       (clk),
    .rd_sel    (lk_sel),
    .rd_set    (lk_set),
    .rd_word   (lk_wsel),
    .rd_data   (lk_word),
    .fill_en   (fill_en),
    .fill_set  (miss_addr[OFS_W+SEL_W +: SET_W]),
    .fill_data (rf_data),
    .ww_en     (ww_en),
    .ww_sel    (lk_sel),
    .ww_set    (lk_set),
    .ww_word   (lk_wsel),
    .ww_data   (cpu_wdata)
  );

  vls_ctrl #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .lk_hit    (lk_hit),
    .lk_word   (lk_word),
    .rf_valid  (rf_valid),
    .rf_data   (rf_data),
    .cpu_ack   (cpu_ack),
    .cpu_rdata (cpu_rdata),
    .cpu_busy  (cpu_busy),
    .rf_req    (rf_req),
    .rf_addr   (rf_addr),
    .rf_mask   (rf_mask),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .fill_en   (fill_en),
    .ww_en     (ww_en),
    .miss_addr (miss_addr),
    .lsz       (lsz_q),
    .ev_accept (ev_accept),
    .ev_hit    (ev_hit),
    .ev_miss   (ev_miss),
    .ev_cfg    (ev_cfg)
  );
endmodule

// File: rtl/vls_dcache_chk.sv
`timescale 1ns/1ps
module vls_dcache_chk
  import vls_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ev_accept,
  input logic             ev_hit,
  input logic             ev_miss,
  input logic             ev_cfg,
  input logic             cpu_we,
  input logic             cpu_ack,
  input logic             cpu_busy,
  input logic             rf_req,
  input logic [NSUB-1:0]  rf_mask,
  input logic             rf_valid,
  input logic             mem_we,
  input lsz_t             lsz,
  input logic [SEL_W-1:0] miss_sel
);
  a_r2_hit_no_refill: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (cpu_ack && !rf_req));

  a_r3_group_size: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |-> ($countones(rf_mask) == (32'd1 << lsz)));

  a_r3_group_holds_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |-> rf_mask[miss_sel]);

  a_r5_ack_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_busy && rf_valid) |=> (cpu_ack && !cpu_busy));

  a_r7_cfg_stays_local: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cfg |=> (cpu_ack && !mem_we && !rf_req));

  a_r9_store_writes_through: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && cpu_we && !ev_cfg) |=> (mem_we && cpu_ack));

  a_r10_single_refill: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |=> !rf_req);

  a_r10_busy_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (cpu_busy && rf_req));
endmodule

bind vls_dcache vls_dcache_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_accept (ev_accept),
  .ev_hit    (ev_hit),
  .ev_miss   (ev_miss),
  .ev_cfg    (ev_cfg),
  .cpu_we    (cpu_we),
  .cpu_ack   (cpu_ack),
  .cpu_busy  (cpu_busy),
  .rf_req    (rf_req),
  .rf_mask   (rf_mask),
  .rf_valid  (rf_valid),
  .mem_we    (mem_we),
  .lsz       (lsz_q),
  .miss_sel  (miss_sel)
);

// File: tb/vls_dcache_test.sv
`timescale 1ns/1ps
module vls_dcache_test;
  localparam int          MEM_LAT  = 3;
  localparam int          MEM_WORDS = 16384;
  localparam logic [31:0] CFG      = 32'hFFFF_FFF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [31:0]   cpu_addr = '0;
  logic [31:0]   cpu_wdata = '0;
  logic          cpu_ack;
  logic [31:0]   cpu_rdata;
  logic          cpu_busy;
  logic          rf_req;
  logic [31:0]   rf_addr;
  logic [7:0]    rf_mask;
  logic          rf_valid = 1'b0;
  logic [2047:0] rf_data = '0;
  logic          mem_we;
  logic [31:0]   mem_addr;
  logic [31:0]   mem_wdata;

  always #4 clk = ~clk;

  vls_dcache uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy), .rf_req(rf_req),
    .rf_addr(rf_addr), .rf_mask(rf_mask), .rf_valid(rf_valid),
    .rf_data(rf_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  // behavioural backing memory and its observation counters
  logic [31:0] mem [MEM_WORDS];
  int          refill_cnt = 0;
  int          wr_cnt = 0;
  logic [7:0]  last_mask = '0;
  logic [31:0] last_raddr = '0;
  logic [31:0] last_waddr = '0;
  logic [31:0] last_wdata = '0;
  int          wait_cnt = 0;
  logic [31:0] pend_base = '0;
  logic [7:0]  pend_mask = '0;

  // bench model of the cache
  logic [31:0] exp_mem [MEM_WORDS];
  bit          exp_v [512];
  logic [17:0] exp_tag [512];
  logic [1:0]  exp_lsz = 2'b00;

  function automatic logic [31:0] seed_word(input int i);
    return (32'(i) * 32'h9E37_79B9) + 32'h1357_9BDF;
  endfunction

  // aligned group, computed as a shifted run of ones
  function automatic logic [7:0] exp_group(input int sub, input logic [1:0] code);
    int span;
    int lo;
    span = 1 << code;
    lo = (sub >> code) << code;
    return 8'(((1 << span) - 1) << lo);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem[i] = seed_word(i);
      exp_mem[i] = seed_word(i);
    end
    for (int i = 0; i < 512; i++) begin
      exp_v[i] = 1'b0;
      exp_tag[i] = '0;
    end
  end

  // memory side, driven between clock edges
  initial begin
    forever begin
      @(negedge clk);
      rf_valid = 1'b0;
      if (mem_we) begin
        mem[mem_addr[15:2]] = mem_wdata;
        wr_cnt++;
        last_waddr = mem_addr;
        last_wdata = mem_wdata;
      end
      if (wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) begin
          for (int s = 0; s < 8; s++)
            for (int w = 0; w < 8; w++)
              rf_data[s*256 + w*32 +: 32] = pend_mask[s] ?
                mem[int'(pend_base[15:2]) + s*8 + w] : 32'hDEAD_BEEF;
          rf_valid = 1'b1;
        end
      end
      if (rf_req) begin
        refill_cnt++;
        last_mask = rf_mask;
        last_raddr = rf_addr;
        pend_base = rf_addr;
        pend_mask = rf_mask;
        wait_cnt = MEM_LAT - 1;
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd);
    int cyc;
    int rc0;
    int wc0;
    int line;
    bit busy1;
    bit is_cfg;
    bit pred_hit;
    logic [31:0] rd;
    logic [7:0] em;
    is_cfg = (addr == CFG);
    line = int'(addr[13:5]);
    pred_hit = exp_v[line] && (exp_tag[line] == addr[31:14]);
    rc0 = refill_cnt;
    wc0 = wr_cnt;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    cyc = 0;
    busy1 = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        cpu_req = 1'b0;
        busy1 = cpu_busy;
      end
    end while (!cpu_ack && cyc <= 40);
    rd = cpu_rdata;
    #1;
    if (cyc > 40) begin
      chk(1'b0, "R10 access timeout", 64'(cyc), 64'(MEM_LAT + 1));
      return;
    end
    chk(!cpu_busy, "R10 busy low at ack", 64'(cpu_busy), 0);
    if (is_cfg) begin
      chk(refill_cnt == rc0 && wr_cnt == wc0, "R7 config access stays local",
          64'(refill_cnt - rc0 + wr_cnt - wc0), 0);
      chk(cyc == 1, "R7 config ack latency", 64'(cyc), 1);
      if (we) exp_lsz = wd[1:0];
      else chk(rd == {30'b0, exp_lsz}, "R7 line-size readback", 64'(rd), 64'(exp_lsz));
    end else if (we) begin
      chk(cyc == 1, "R9 store ack latency", 64'(cyc), 1);
      chk(wr_cnt == wc0 + 1 && last_waddr == addr && last_wdata == wd,
          "R9 write-through", {last_waddr, last_wdata}, {addr, wd});
      chk(refill_cnt == rc0, "R9 store never refills", 64'(refill_cnt - rc0), 0);
      exp_mem[addr[15:2]] = wd;
    end else begin
      chk(rd == exp_mem[addr[15:2]], "R6 load data", 64'(rd), 64'(exp_mem[addr[15:2]]));
      if (pred_hit) begin
        chk(cyc == 1 && refill_cnt == rc0, "R2 R4 hit without refill",
            64'(refill_cnt - rc0), 0);
        chk(!busy1, "R10 busy low on hit", 64'(busy1), 0);
      end else begin
        em = exp_group(int'(addr[7:5]), exp_lsz);
        chk(refill_cnt == rc0 + 1, "R3 one refill per miss", 64'(refill_cnt - rc0), 1);
        chk(last_mask == em, "R3 refill group mask", 64'(last_mask), 64'(em));
        chk(last_raddr == {addr[31:8], 8'h00}, "R3 refill address",
            64'(last_raddr), 64'({addr[31:8], 8'h00}));
        chk(cyc == MEM_LAT + 1, "R5 fixed miss latency", 64'(cyc), 64'(MEM_LAT + 1));
        chk(busy1, "R10 busy during refill", 64'(busy1), 1);
        for (int s = 0; s < 8; s++)
          if (em[s]) begin
            exp_v[(line & ~7) | s] = 1'b1;
            exp_tag[(line & ~7) | s] = addr[31:14];
          end
      end
    end
  endtask

  task automatic expect_hit(input logic [31:0] addr, input string req);
    int line;
    line = int'(addr[13:5]);
    chk(exp_v[line] && exp_tag[line] == addr[31:14], req, 0, 1);
    access(1'b0, addr, '0);
  endtask

  initial begin
    int unused;
    unused = $urandom(20240611);
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!cpu_busy && !cpu_ack && !rf_req && !mem_we, "R1 reset outputs",
        {cpu_busy, cpu_ack, rf_req, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_busy && !cpu_ack && !rf_req && !mem_we, "R1 idle after reset",
        {cpu_busy, cpu_ack, rf_req, mem_we}, 0);
    access(1'b0, CFG, '0);                 // R1: code 00 after reset
    access(1'b0, 32'h0000_0040, '0);       // R1 all invalid: miss, 32 B group
    access(1'b0, 32'h0000_0040, '0);       // R2 hit
    access(1'b0, 32'h0000_0020, '0);       // R4 neighbour outside mask misses
    access(1'b1, CFG, 32'h0000_0001);      // R7 64 B
    access(1'b0, CFG, '0);
    access(1'b0, 32'h0000_1460, '0);       // R3 two sub-arrays 2..3
    expect_hit(32'h0000_1444, "R4 group partner valid");
    access(1'b1, CFG, 32'h0000_0006);      // R7 only bits [1:0]: 128 B
    access(1'b0, CFG, '0);
    access(1'b0, 32'h0000_2AA8, '0);       // R3 four sub-arrays 4..7
    expect_hit(32'h0000_2A9C, "R4 group partner valid");
    expect_hit(32'h0000_2AE0, "R4 group partner valid");
    access(1'b1, CFG, 32'h0000_0003);      // 256 B
    access(1'b0, 32'h0000_3300, '0);       // R3 all eight
    expect_hit(32'h0000_33E4, "R4 group partner valid");
    expect_hit(32'h0000_0040, "R8 no flush on size change");
    expect_hit(32'h0000_1460, "R8 no flush on size change");
    access(1'b1, 32'h0000_0044, 32'hCAFE_0001);   // R9 store hit
    expect_hit(32'h0000_0044, "R9 store hit updated word");
    access(1'b1, 32'h0000_8000, 32'hCAFE_0002);   // R9 store miss, no allocate
    access(1'b0, 32'h0000_8000, '0);              // misses, refills set 0
    access(1'b0, 32'h0000_0040, '0);              // conflict: evicted, misses
    // random mix
    for (int k = 0; k < 500; k++) begin
      int r;
      logic [31:0] a;
      r = int'($urandom % 16);
      a = {16'h0000, 16'($urandom) & 16'hFFFC};
      if (r == 0)      access(1'b1, CFG, $urandom);
      else if (r == 1) access(1'b0, CFG, '0);
      else if (r < 5)  access(1'b1, a, $urandom);
      else             access(1'b0, a, '0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule